// File: doc/BRIEF.md
# Timing Edge and Address Serial Encoder

This block combines the timing triggers of many detector channels onto one output line. When an enabled channel fires while the encoder is idle, the output rises at once, through logic only. That edge therefore carries the event time with no clock quantisation. On the next clock edge the encoder does three things: it captures the number of the firing channel, it raises a block signal that goes back to every channel, and it starts a short synchronous frame on the same line.

The frame has four parts:
- the line is held high for one more cycle;
- the line drops low for one stop slot;
- the channel number follows, one bit per clock, least significant bit first;
- block is released.

If several channels fire in the same cycle, the highest channel number wins. A channel whose trigger is still high when blocking ends, or when reset ends, must go low before it can start another event. A downstream timestamper therefore needs only one wire per encoder.

Top module: `trig_serializer`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `ser_o` and `block_o` are both low.
- R2: While idle, a high on any enabled channel trigger drives `ser_o` high in the same cycle, before any clock edge.
- R3: On the first clock edge that sees an enabled trigger while idle, `block_o` rises and `ser_o` stays high for the cycle that follows (the lead slot).
- R4: The cycle after the lead slot is a stop slot in which `ser_o` is low.
- R5: After the stop slot, `ser_o` carries the captured channel number, one bit per clock cycle, least significant bit first, over AW = log2(NCH) cycles (5 for 32 channels).
- R6: When several enabled triggers are high on the capture edge, the number sent is that of the highest-numbered channel.
- R7: `block_o` stays high for exactly AW+2 clock cycles (7 for 32 channels). It is released on the edge that ends the last address bit, after which `ser_o` is low unless a new enabled trigger is present.
- R8: Trigger activity while `block_o` is high changes neither the address being sent nor `ser_o`.
- R9: A trigger that is high while `block_o` is high, or high when reset ends, is ignored until it has been low for at least one clock edge. Its next rise is then a new event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | NCH | Per-channel timing trigger lines, active high |
| ser_o | output | 1 | Serial line: asynchronous event edge, then lead, stop and address slots |
| block_o | output | 1 | High while a frame is in progress; tells every channel to hold off |

## Verification
A wrong sequencer state shows up on `ser_o` within one cycle of the capture edge: a missing lead slot, a high stop slot, or a shifted bit. A wrong frame length moves the fall of `block_o` off the seventh cycle. A fault in the per-channel enable flags shows up right after release: a held or late trigger makes `ser_o` rise when it should stay low, or a new event fails to produce its edge. A fault in the priority logic shows up only when two or more channels fire together, as a wrong bit within the five address slots. For this reason the sweeps include multi-channel patterns and triggers injected during blocking.

// File: rtl/ts_pkg.sv
package ts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_STOP = 2'd2,
        ST_ADDR = 2'd3
    } seq_state_t;

    // cycles block stays high: lead + stop + address bits
    function automatic int frame_cycles(input int aw);
        return aw + 2;
    endfunction

endpackage

// File: rtl/ts_prio.sv
module ts_prio #(
    parameter int NCH = 32,
    localparam int AW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic [AW-1:0]  idx,
    output logic           any
);
    // ascending scan: the last (highest) set bit wins
    always_comb begin
        idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i]) idx = AW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/ts_arm.sv
module ts_arm #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trig,
    input  logic           hold,
    output logic [NCH-1:0] armed
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)           armed[g] <= 1'b0;
            else if (!trig[g]) armed[g] <= 1'b1;
            else if (hold)     armed[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/ts_seq.sv
module ts_seq
    import ts_pkg::*;
#(
    parameter int AW = 5,
    localparam int CW = $clog2(AW) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic [AW-1:0] addr_in,
    output logic          busy,
    output logic          frame_bit
);
    seq_state_t    state;
    logic [AW-1:0] addr_sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_sh <= '0;
            cnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (hit) begin
                    addr_sh <= addr_in;
                    state   <= ST_LEAD;
                end
                ST_LEAD: state <= ST_STOP;
                ST_STOP: begin
                    cnt   <= '0;
                    state <= ST_ADDR;
                end
                ST_ADDR: begin
                    addr_sh <= addr_sh >> 1;
                    cnt     <= cnt + 1'b1;
                    if (cnt == CW'(AW - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_LEAD: frame_bit = 1'b1;
            ST_ADDR: frame_bit = addr_sh[0];
            default: frame_bit = 1'b0;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/trig_serializer.sv
module trig_serializer #(
    parameter int NCH = 32,
    localparam int AW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trig_i,
    output logic           ser_o,
    output logic           block_o
);
    logic [NCH-1:0] armed;
    logic [NCH-1:0] live;
    logic [AW-1:0]  win_idx;
    logic           any_live;
    logic           busy;
    logic           frame_bit;

    ts_arm #(.NCH(NCH)) u_arm (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig_i),
        .hold  (busy),
        .armed (armed)
    );

    assign live = trig_i & armed & {NCH{~busy}};

    ts_prio #(.NCH(NCH)) u_prio (
        .req (live),
        .idx (win_idx),
        .any (any_live)
    );

    ts_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hit       (any_live),
        .addr_in   (win_idx),
        .busy      (busy),
        .frame_bit (frame_bit)
    );

    // output OR: unclocked event edge while idle, framed bits while busy
    assign ser_o   = busy ? frame_bit : any_live;
    assign block_o = busy;

endmodule

// File: rtl/ts_checker.sv
module ts_checker
    import ts_pkg::*;
#(
    parameter int NCH = 32
) (
    input logic clk,
    input logic rst,
    input logic ser_o,
    input logic block_o
);
    localparam int AW    = $clog2(NCH);
    localparam int FRAME = frame_cycles(AW);

    logic [7:0] len;

    always_ff @(posedge clk) begin
        if (rst)          len <= '0;
        else if (block_o) len <= len + 8'd1;
        else              len <= '0;
    end

    // R2
    idle_edge_starts_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (!block_o && ser_o) |=> block_o);

    // R3
    lead_slot_high_chk: assert property (@(posedge clk) disable iff (rst)
        (block_o && len == 8'd0) |-> ser_o);

    // R4
    stop_slot_low_chk: assert property (@(posedge clk) disable iff (rst)
        (block_o && len == 8'd1) |-> !ser_o);

    // R7
    block_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(block_o) |-> (len == 8'(FRAME)));

    // R7
    block_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        block_o |-> (len < 8'(FRAME)));

endmodule

bind trig_serializer ts_checker #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ser_o   (ser_o),
    .block_o (block_o)
);

// File: tb/trig_serializer_test.sv
module trig_serializer_test;
    localparam int NCH = 32;
    localparam int AW  = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] trig = '0;
    logic           ser;
    logic           blk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    trig_serializer #(.NCH(NCH)) uut (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig),
        .ser_o   (ser),
        .block_o (blk)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    function automatic int hi_bit(input logic [NCH-1:0] p);
        int r = 0;
        for (int i = 0; i < NCH; i++) if (p[i]) r = i;
        return r;
    endfunction

    // one frame: pat applied while idle; intf injected during blocking
    task automatic run_frame(input logic [NCH-1:0] pat, input bit keep,
                             input logic [NCH-1:0] intf);
        int exp_addr;
        logic [NCH-1:0] base;
        exp_addr = hi_bit(pat);
        base = keep ? pat : '0;
        trig = pat;
        #1;
        check("R2 async edge", ser, 1);
        check("R2 idle block", blk, 0);
        tick;
        check("R3 block rise", blk, 1);
        check("R3 lead slot", ser, 1);
        trig = base;
        tick;
        check("R4 stop slot", ser, 0);
        trig = base | intf;
        for (int k = 0; k < AW; k++) begin
            tick;
            check("R5 R6 R8 address bit", ser, (exp_addr >> k) & 1);
            check("R7 block held", blk, 1);
            if (k == 1) trig = base;
        end
        tick;
        check("R7 block released", blk, 0);
        check("R7 line low after frame", ser, 0);
        tick;
        check("R8 no late event", ser, 0);
        check("R8 no late block", blk, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] x;
        // R1 and R9: trigger held through reset
        trig = 32'h0000_0100;
        repeat (3) tick;
        check("R1 reset ser", ser, 0);
        check("R1 reset block", blk, 0);
        rst = 1'b0;
        tick;
        check("R1 idle ser", ser, 0);
        check("R9 held at reset ignored", blk, 0);
        tick;
        check("R9 held at reset ignored", ser, 0);
        trig = '0;
        tick;
        run_frame(32'h0000_0100, 1'b0, '0);

        // R5: every single channel
        for (int i = 0; i < NCH; i++) run_frame(NCH'(1) << i, 1'b0, '0);

        // R6: all channels from 0 up to i together
        for (int i = 1; i < NCH; i++) run_frame({NCH{1'b1}} >> (NCH - 1 - i), 1'b0, '0);

        // R6 R8: pseudo-random patterns with interference during blocking
        x = 32'h1234_5678;
        for (int n = 0; n < 24; n++) begin
            x ^= x << 13;
            x ^= x >> 17;
            x ^= x << 5;
            run_frame(x, 1'b0, ~x);
        end

        // R9: trigger kept high past release
        run_frame(32'h0000_0020, 1'b1, '0);
        repeat (3) begin
            tick;
            check("R9 held trigger ignored", ser, 0);
            check("R9 held trigger no block", blk, 0);
        end
        trig = '0;
        tick;
        run_frame(32'h0000_0020, 1'b0, '0);

        // R8 R9: trigger rising during blocking and held past release
        trig = 32'h0000_0001;
        #1;
        check("R2 async edge ch0", ser, 1);
        tick;
        trig = 32'h8000_0000;
        repeat (AW + 2) tick;
        check("R9 blocked riser release", blk, 0);
        check("R8 blocked riser not sent", ser, 0);
        tick;
        check("R9 blocked riser still ignored", ser, 0);
        trig = '0;
        tick;
        run_frame(32'h8000_0000, 1'b0, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule